// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the time-varying attenuation for one operator of a two-operator FM voice. It watches the channel trigger bit. A rising trigger starts a note with an attack phase. A falling trigger starts a release phase. Between the two, the envelope moves from attack through decay to a sustain level, or it skips sustain and goes directly into release. The output is a 7-bit attenuation in which 0 means full volume and 127 means silence.

Each phase runs at a rate chosen by a 4-bit code. Code 0 freezes the phase. The step interval halves for each code step above that. Steps advance only on a per-sample enable pulse. One instance serves as a modulator or as a carrier: a modulator with its sustain bit set ignores key-off. The channel sustain bit replaces the release code with a fixed code. A test input forces the output to full volume while the envelope itself keeps running underneath.

Top module: `fm_env_gen`

## Requirements
- R1: After reset, `atten_out` is 127 and `phase_out` is 0 (idle). The phase codes are: idle 0, attack 1, decay 2, sustain 3, release 4.
- R2: A 0-to-1 change of `key_trig` sets the phase to attack (1) on that clock edge and keeps the current attenuation. Each attack step lowers the attenuation by 8, saturating at 0. On the next sample after the attenuation reaches 0, the phase becomes decay (2).
- R3: Holding or rewriting the same trigger value creates no key-on or key-off event, so the phase and attenuation continue undisturbed.
- R4: A rate code r from 1 to 15 makes one step every 2^(15-r) sample pulses, counted from the start of the phase. Code 0 never steps. Without `sample_en`, nothing steps.
- R5: In decay, each step adds 1 to the attenuation until the attenuation reaches or exceeds `sustain_lvl`*8. On the next sample, the phase becomes sustain (3) if `op_sustain_en` is 1, or release (4) if it is 0.
- R6: A 1-to-0 change of `key_trig` in attack, decay or sustain moves the phase to release (4) on that edge, with no change in attenuation. This applies when `is_carrier` is 1 or `op_sustain_en` is 0.
- R7: When `is_carrier` is 0 and `op_sustain_en` is 1, key-off is ignored and the envelope continues its phases.
- R8: When `chan_sustain` is 1, release uses rate code 5 (one step per 1024 samples) regardless of `release_rate`.
- R9: In release, each step adds 1 up to 127. On the next sample after the attenuation reaches 127, the phase becomes idle (0).
- R10: While `test_zero` is 1, `atten_out` is 0, and the internal envelope keeps advancing. Its value appears once `test_zero` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | One-cycle pulse per output sample |
| key_trig | input | 1 | Channel trigger bit (key on when 1) |
| attack_rate | input | 4 | Attack rate code |
| decay_rate | input | 4 | Decay rate code |
| sustain_lvl | input | 4 | Sustain level, 0 loudest to 15 quietest |
| release_rate | input | 4 | Patch release rate code |
| op_sustain_en | input | 1 | Operator sustain enable from the patch |
| chan_sustain | input | 1 | Channel sustain, forces release code 5 |
| is_carrier | input | 1 | 1 for carrier, 0 for modulator |
| test_zero | input | 1 | Test override forcing output attenuation 0 |
| atten_out | output | 7 | Attenuation, 0 full volume, 127 silent |
| phase_out | output | 3 | Current envelope phase code |

## Verification
Full notes are played on a carrier with the sustain bit set and also cleared, which separates a sustained hold from a direct fall into release. Key-off is applied during attack, during decay and during sustain, and is given to a modulator that should ignore it; this shows whether release starts from the current level and whether the operator roles are distinguished. Rate code 0, a throttled sample enable and several rate codes check the step interval, and a long release under channel sustain with a fast patch release code confirms the substitution. A cycle-level reference model in the bench follows every table scenario, and hand-computed values anchor the directed cases.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ATTACK  = 3'd1,
    PH_DECAY   = 3'd2,
    PH_SUSTAIN = 3'd3,
    PH_RELEASE = 3'd4
  } env_phase_e;
endpackage

// File: rtl/fm_env_edge.sv
module fm_env_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rise_ev,
  output logic fall_ev
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig;
  end

  assign rise_ev = trig & ~trig_q;
  assign fall_ev = ~trig & trig_q;

  // R3: a held trigger cannot produce two key-on events in a row
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> !rise_ev);
endmodule

// File: rtl/fm_env_rate.sv
module fm_env_rate #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              clear,
  input  logic [RATE_W-1:0] rate,
  output logic              step_ev
);
  localparam int TOP_CODE = (1 << RATE_W) - 1;
  localparam int CNT_W    = TOP_CODE;

  logic [CNT_W-1:0] cnt_q;

  // interval of 2^(TOP_CODE-code) samples, expressed as last count value
  function automatic logic [CNT_W-1:0] step_limit(input logic [RATE_W-1:0] code);
    return CNT_W'((32'd1 << (TOP_CODE - int'(code))) - 32'd1);
  endfunction

  assign step_ev = sample_en && (rate != '0) && (cnt_q >= step_limit(rate));

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clear || step_ev)         cnt_q <= '0;
    else if (sample_en && rate != '0)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen #(
  parameter int ATT_W         = 7,
  parameter int RATE_W        = 4,
  parameter int ATTACK_STEP   = 8,
  parameter int CHAN_SUS_RATE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              key_trig,
  input  logic [RATE_W-1:0] attack_rate,
  input  logic [RATE_W-1:0] decay_rate,
  input  logic [RATE_W-1:0] sustain_lvl,
  input  logic [RATE_W-1:0] release_rate,
  input  logic              op_sustain_en,
  input  logic              chan_sustain,
  input  logic              is_carrier,
  input  logic              test_zero,
  output logic [ATT_W-1:0]  atten_out,
  output logic [2:0]        phase_out
);
  import fm_env_pkg::*;

  localparam logic [ATT_W-1:0] MAX_ATT = '1;
  localparam int SL_SHIFT = ATT_W - RATE_W;

  env_phase_e        phase_q, phase_nxt;
  logic [ATT_W-1:0]  atten_q, atten_nxt;
  logic [RATE_W-1:0] cur_rate;
  logic key_on_ev, key_off_ev, key_off_taken, release_ok;
  logic step_ev, rate_clear, decay_done;

  function automatic logic [ATT_W-1:0] attack_next(input logic [ATT_W-1:0] a);
    if (a <= ATT_W'(ATTACK_STEP)) return '0;
    return a - ATT_W'(ATTACK_STEP);
  endfunction

  function automatic logic [ATT_W-1:0] sus_target(input logic [RATE_W-1:0] sl);
    return ATT_W'(sl) << SL_SHIFT;
  endfunction

  function automatic logic [ATT_W-1:0] sat_inc(input logic [ATT_W-1:0] a);
    return (a == MAX_ATT) ? a : a + ATT_W'(1);
  endfunction

  fm_env_edge u_edge (
    .clk(clk), .rst_n(rst_n), .trig(key_trig),
    .rise_ev(key_on_ev), .fall_ev(key_off_ev)
  );

  fm_env_rate #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .clear(rate_clear),
    .rate(cur_rate), .step_ev(step_ev)
  );

  assign release_ok    = is_carrier | ~op_sustain_en;
  assign key_off_taken = key_off_ev & release_ok & (phase_q != PH_IDLE);
  assign decay_done    = atten_q >= sus_target(sustain_lvl);

  always_comb begin
    case (phase_q)
      PH_ATTACK:  cur_rate = attack_rate;
      PH_DECAY:   cur_rate = decay_rate;
      PH_RELEASE: cur_rate = chan_sustain ? RATE_W'(CHAN_SUS_RATE) : release_rate;
      default:    cur_rate = '0;
    endcase
  end

  always_comb begin
    phase_nxt = phase_q;
    atten_nxt = atten_q;
    if (key_on_ev) begin
      phase_nxt = PH_ATTACK;
    end else if (key_off_taken) begin
      phase_nxt = PH_RELEASE;
    end else if (sample_en) begin
      case (phase_q)
        PH_ATTACK: begin
          if (atten_q == '0)  phase_nxt = PH_DECAY;
          else if (step_ev)   atten_nxt = attack_next(atten_q);
        end
        PH_DECAY: begin
          if (decay_done)     phase_nxt = op_sustain_en ? PH_SUSTAIN : PH_RELEASE;
          else if (step_ev)   atten_nxt = sat_inc(atten_q);
        end
        PH_RELEASE: begin
          if (atten_q == MAX_ATT) phase_nxt = PH_IDLE;
          else if (step_ev)       atten_nxt = sat_inc(atten_q);
        end
        default: ;
      endcase
    end
  end

  assign rate_clear = key_on_ev | (phase_nxt != phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      atten_q <= MAX_ATT;
    end else begin
      phase_q <= phase_nxt;
      atten_q <= atten_nxt;
    end
  end

  assign atten_out = test_zero ? '0 : atten_q;
  assign phase_out = phase_q;

  // R2: attack never raises attenuation
  assert_attack_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ATTACK) |=> (atten_q <= $past(atten_q)));
  // R4: a halted rate or missing sample pulse leaves attenuation alone
  assert_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_rate == '0) |=> $stable(atten_q));
  assert_nosample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(atten_q));
  // R6: release starts at the level reached, no jump
  assert_release_nojump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_off_ev && !key_on_ev && release_ok && phase_q != PH_IDLE)
      |=> (phase_q == PH_RELEASE && atten_q == $past(atten_q)));
  // R7: a sustaining modulator does not enter release on key-off
  assert_mod_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_off_ev && !is_carrier && op_sustain_en && phase_q != PH_RELEASE)
      |=> (phase_q != PH_RELEASE));
  // R9: idle always means silence
  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (atten_q == MAX_ATT));
endmodule

// File: tb/fm_env_gen_tb.sv
module fm_env_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_trig = 1'b0;
  logic [3:0] attack_rate = 4'd15, decay_rate = 4'd15, sustain_lvl = 4'd2, release_rate = 4'd15;
  logic op_sustain_en = 1'b1, chan_sustain = 1'b0, is_carrier = 1'b1, test_zero = 1'b0;
  logic [6:0] atten_out;
  logic [2:0] phase_out;
  logic sample_en;
  int samp_div = 1;
  int cyc = 0;
  int n_tests = 0, n_fail = 0, mism = 0;

  always #4 clk = ~clk;  // 125 MHz

  always @(negedge clk) cyc <= cyc + 1;
  assign sample_en = (samp_div != 0) && ((cyc % samp_div) == 0);

  fm_env_gen dut_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .key_trig(key_trig),
    .attack_rate(attack_rate), .decay_rate(decay_rate), .sustain_lvl(sustain_lvl),
    .release_rate(release_rate), .op_sustain_en(op_sustain_en),
    .chan_sustain(chan_sustain), .is_carrier(is_carrier), .test_zero(test_zero),
    .atten_out(atten_out), .phase_out(phase_out)
  );

  // cycle-level reference built from the requirements
  int m_ph, m_att, m_cnt;
  bit m_trig;
  always @(posedge clk) begin
    int r, span;
    bit up, down;
    if (!rst_n) begin
      m_trig = 0; m_ph = 0; m_att = 127; m_cnt = 0;
    end else begin
      up = key_trig && !m_trig;
      down = !key_trig && m_trig;
      m_trig = key_trig;
      if (up) begin
        m_ph = 1; m_cnt = 0;
      end else if (down && (is_carrier || !op_sustain_en) && m_ph != 0) begin
        m_ph = 4; m_cnt = 0;
      end else if (sample_en) begin
        r = (m_ph == 1) ? attack_rate : (m_ph == 2) ? decay_rate :
            (m_ph == 4) ? (chan_sustain ? 5 : release_rate) : 0;
        span = 1 << (15 - r);
        if (m_ph == 1 && m_att == 0) begin m_ph = 2; m_cnt = 0; end
        else if (m_ph == 2 && m_att >= sustain_lvl * 8) begin
          m_ph = op_sustain_en ? 3 : 4; m_cnt = 0;
        end else if (m_ph == 4 && m_att == 127) begin m_ph = 0; m_cnt = 0; end
        else if (r != 0 && (m_ph == 1 || m_ph == 2 || m_ph == 4)) begin
          if (m_cnt + 1 >= span) begin
            m_cnt = 0;
            if (m_ph == 1) m_att = (m_att <= 8) ? 0 : m_att - 8;
            else if (m_att < 127) m_att = m_att + 1;
          end else m_cnt = m_cnt + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && ((phase_out != 3'(m_ph)) || (atten_out != (test_zero ? 7'd0 : 7'(m_att)))))
      mism <= mism + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] ar, dr, sl, rr;
    logic osus, car, csus;
    logic [3:0] div;
    logic [15:0] on_c, off_c;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{4'd15, 4'd15, 4'd2, 4'd15, 1'b1, 1'b1, 1'b0, 4'd1, 16'd60,  16'd200},  // R2 R5 R6 R9
    '{4'd14, 4'd13, 4'd4, 4'd12, 1'b0, 1'b1, 1'b0, 4'd3, 16'd300, 16'd400},  // R5 direct release
    '{4'd15, 4'd0,  4'd3, 4'd15, 1'b1, 1'b1, 1'b0, 4'd1, 16'd50,  16'd150},  // R4 decay halted
    '{4'd12, 4'd15, 4'd1, 4'd14, 1'b1, 1'b0, 1'b0, 4'd1, 16'd100, 16'd100},  // R7 modulator
    '{4'd15, 4'd15, 4'd2, 4'd15, 1'b1, 1'b1, 1'b0, 4'd1, 16'd5,   16'd200},  // R6 off in attack
    '{4'd13, 4'd14, 4'd6, 4'd11, 1'b1, 1'b1, 1'b1, 4'd1, 16'd200, 16'd1500}  // R8
  };

  initial begin
    int base;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    check("R1 reset atten", atten_out, 127);
    check("R1 reset phase", phase_out, 0);

    // R2 / R5 full rise at rate 15
    key_trig = 1'b1;
    tick(1);
    check("R2 attack entered", phase_out, 1);
    check("R2 level kept at key-on", atten_out, 127);
    tick(16);
    check("R2 attack reaches 0", atten_out, 0);
    tick(1);
    check("R2 decay after attack", phase_out, 2);
    tick(16);
    check("R5 decay at target", atten_out, 16);
    tick(1);
    check("R5 sustain entered", phase_out, 3);

    // R3 rewrite same trigger
    key_trig = 1'b1;
    tick(10);
    check("R3 phase unchanged", phase_out, 3);
    check("R3 atten unchanged", atten_out, 16);

    // R10 with R6 release running underneath
    test_zero = 1'b1;
    key_trig = 1'b0;
    tick(20);
    check("R10 forced zero", atten_out, 0);
    check("R6 release phase", phase_out, 4);
    test_zero = 1'b0;
    #1;
    check("R10 hidden envelope ran", atten_out, 35);
    tick(100);
    check("R9 idle phase", phase_out, 0);
    check("R9 idle atten", atten_out, 127);

    // R4 halt and sample gating
    attack_rate = 4'd0;
    key_trig = 1'b1;
    tick(50);
    check("R4 rate 0 halts", atten_out, 127);
    key_trig = 1'b0;
    tick(2);
    check("R9 back to idle", phase_out, 0);
    attack_rate = 4'd15;
    samp_div = 0;
    key_trig = 1'b1;
    tick(20);
    check("R4 no sample no step", atten_out, 127);
    samp_div = 1;
    tick(1);
    check("R4 step on sample", atten_out, 119);
    key_trig = 1'b0;
    tick(40);

    // R8 channel sustain release
    chan_sustain = 1'b1;
    key_trig = 1'b1;
    tick(40);
    check("R8 setup sustain", atten_out, 16);
    key_trig = 1'b0;
    tick(1);
    check("R8 release entered", phase_out, 4);
    tick(1023);
    check("R8 no step before 1024", atten_out, 16);
    tick(1);
    check("R8 step at 1024", atten_out, 17);
    chan_sustain = 1'b0;
    tick(200);
    check("R8 patch rate back", phase_out, 0);

    // table of scenarios against the reference
    foreach (ROWS[i]) begin
      base = mism;
      attack_rate = ROWS[i].ar; decay_rate = ROWS[i].dr;
      sustain_lvl = ROWS[i].sl; release_rate = ROWS[i].rr;
      op_sustain_en = ROWS[i].osus; is_carrier = ROWS[i].car;
      chan_sustain = ROWS[i].csus; samp_div = ROWS[i].div;
      key_trig = 1'b1;
      tick(ROWS[i].on_c);
      key_trig = 1'b0;
      tick(ROWS[i].off_c);
      check($sformatf("R2 R4 R5 R6 R7 R8 R9 row %0d model mismatches", i), mism - base, 0);
    end
    // R7 direct: modulator held after key-off
    op_sustain_en = 1'b1; is_carrier = 1'b0; chan_sustain = 1'b0; samp_div = 1;
    attack_rate = 4'd15; decay_rate = 4'd15; sustain_lvl = 4'd3;
    key_trig = 1'b1;
    tick(60);
    key_trig = 1'b0;
    tick(30);
    check("R7 modulator stays sustained", phase_out, 3);
    check("R7 modulator level", atten_out, 24);
    check("R1 R2 R9 whole-run model agreement", mism, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule